// File: doc/BRIEF.md
# Shared-Pin Parallel I/O Port

This block is a parallel digital I/O port whose pins are each shared between the general-purpose port and a peripheral. Software uses a small register bus with separate write and read strobes. Through it, software sets each pin's direction, writes the output latch, samples the pin levels and clears a retention release flag. Each pin also has a peripheral side with four signals: module enable, output enable, output data, and a returned input value. A per-pin multiplexer decides whether the port or the peripheral drives the pad's enable and data.

Pin inputs pass through a two-stage synchroniser. The resulting sampled level feeds two places: the port read view, and the peripheral input of each pin. The peripheral input is blanked while the port is driving that pin, so a port output never loops back into the peripheral. A parameter mask marks which bits are implemented. A retain input freezes the pad drive through a deep low-power state. The drive stays frozen after the state ends, until software clears the release flag.

Top module: `shared_pin_port`

## Requirements
- R1: Each pin has a direction bit at register address 0. A value of 1 makes the pin an input (pad_oe low). A value of 0 lets the port drive the pin (pad_oe high) with the latch bit on pad_out.
- R2: A synchronous reset sets every implemented direction bit to 1. It also clears the latch, clears the release flag (address 3, bit 0) and clears the read data register, so pad_oe is all zero.
- R3: A read strobe returns, one clock later on bus_rdata, the register at the address: 0 gives direction, 1 gives latch, 2 gives the synchronised pin levels, and 3 gives the release flag in bit 0.
- R4: A write strobe at address 1 or at address 2 loads the output latch at the next clock edge.
- R5: When a pin's periph_en and periph_oe are both high, pad_oe is 1 and pad_out follows periph_out. The port view at address 2 still returns the pin level.
- R6: When periph_en is high and periph_oe is low, the direction and latch bits control the pin as in R1.
- R7: periph_in carries the synchronised pin level when the pin is an input or is owned by the peripheral. It is 0 when the port is driving the pin.
- R8: Bits that are cleared in IMPL_MASK read as 0 at addresses 0, 1 and 2. Writes to them have no effect. For those bits, pad_oe, pad_out and periph_in are 0.
- R9: While retain is high, pad_oe and pad_out keep the values they had before retain rose, and the release flag is set. The hold continues after retain falls, until a write of 0 to address 3 bit 0 while retain is low clears the flag. Writing 1 to that bit does not clear the flag.
- R10: A change on pad_in reaches periph_in and the address-2 view after two clock edges, not after one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register select: 0 direction, 1 latch, 2 pin view, 3 control |
| bus_wdata | input | NPIN | Write data |
| bus_rdata | output | NPIN | Registered read data |
| periph_en | input | NPIN | Per-pin peripheral module enable |
| periph_oe | input | NPIN | Per-pin peripheral output enable |
| periph_out | input | NPIN | Per-pin peripheral output data |
| periph_in | output | NPIN | Per-pin peripheral input data (loop-through blocked) |
| pad_in | input | NPIN | External pin levels |
| pad_oe | output | NPIN | Pad driver enable |
| pad_out | output | NPIN | Pad driver data |
| retain | input | 1 | Deep low-power retention request |

## Verification
The assertions assume three things about the inputs. Reset is held for at least two clock edges. Bus strobes and peripheral signals change away from the clock edge. retain does not rise in the same cycle as a change to the registers or peripheral inputs that set the drive; otherwise the captured values would be those of the prior cycle. The bench drives every input on the falling edge. It raises retain only after the configuration has settled for several cycles, and it holds pad_in steady for at least two edges before it samples periph_in or the pin view.

// File: rtl/spp_pkg.sv
package spp_pkg;

    typedef enum logic [1:0] {
        REG_DIR = 2'd0,
        REG_LAT = 2'd1,
        REG_PIN = 2'd2,
        REG_CTL = 2'd3
    } spp_reg_e;

    localparam int CTL_RELEASE_BIT = 0;

    typedef struct packed {
        logic oe;
        logic dat;
    } spp_drive_t;

    function automatic spp_drive_t pick_drive(input logic periph_owns,
                                              input logic periph_dat,
                                              input logic dir_in,
                                              input logic lat_bit);
        spp_drive_t d;
        if (periph_owns) begin
            d.oe  = 1'b1;
            d.dat = periph_dat;
        end else begin
            d.oe  = ~dir_in;
            d.dat = lat_bit;
        end
        return d;
    endfunction

    function automatic logic feed_periph(input logic pin_lvl,
                                         input logic periph_owns,
                                         input logic dir_in);
        return pin_lvl & (periph_owns | dir_in);
    endfunction

endpackage

// File: rtl/spp_sync.sv
module spp_sync #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NPIN-1:0] raw_in,
    output logic [NPIN-1:0] sync_out
);
    logic [NPIN-1:0] stage1_q;
    logic [NPIN-1:0] stage2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= raw_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;

    // R10
    two_stage_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2)) |-> (sync_out == $past(raw_in, 2)));

endmodule

// File: rtl/spp_regs.sv
module spp_regs
    import spp_pkg::*;
#(
    parameter int              NPIN      = 8,
    parameter logic [NPIN-1:0] IMPL_MASK = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [1:0]      bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    input  logic [NPIN-1:0] pin_sync,
    input  logic            release_flag,
    output logic [NPIN-1:0] dir_q,
    output logic [NPIN-1:0] lat_q,
    output logic            release_clr,
    output logic [NPIN-1:0] bus_rdata
);
    spp_reg_e        sel;
    logic [NPIN-1:0] wmask;
    logic [NPIN-1:0] rd_mux;
    logic [NPIN-1:0] ctl_view;

    assign sel   = spp_reg_e'(bus_addr);
    assign wmask = bus_wdata & IMPL_MASK;

    always_ff @(posedge clk) begin
        if (rst) begin
            dir_q <= IMPL_MASK;
            lat_q <= '0;
        end else if (bus_wr) begin
            case (sel)
                REG_DIR: dir_q <= wmask;
                REG_LAT,
                REG_PIN: lat_q <= wmask;
                default: ;
            endcase
        end
    end

    assign release_clr = bus_wr && (sel == REG_CTL) && !bus_wdata[CTL_RELEASE_BIT];

    always_comb begin
        ctl_view = '0;
        ctl_view[CTL_RELEASE_BIT] = release_flag;
    end

    always_comb begin
        case (sel)
            REG_DIR: rd_mux = dir_q;
            REG_LAT: rd_mux = lat_q;
            REG_PIN: rd_mux = pin_sync & IMPL_MASK;
            default: rd_mux = ctl_view;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    // R2
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (dir_q == IMPL_MASK && lat_q == '0));

    // R3
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == 2'd1) |=> (bus_rdata == $past(lat_q)));

    // R8
    unimpl_regs_chk: assert property (@(posedge clk) disable iff (rst)
        ((dir_q | lat_q) & ~IMPL_MASK) == '0);

endmodule

// File: rtl/spp_pinmux.sv
module spp_pinmux
    import spp_pkg::*;
#(
    parameter int              NPIN      = 8,
    parameter logic [NPIN-1:0] IMPL_MASK = '1
) (
    input  logic [NPIN-1:0] dir_q,
    input  logic [NPIN-1:0] lat_q,
    input  logic [NPIN-1:0] pin_sync,
    input  logic [NPIN-1:0] periph_en,
    input  logic [NPIN-1:0] periph_oe,
    input  logic [NPIN-1:0] periph_out,
    output logic [NPIN-1:0] live_oe,
    output logic [NPIN-1:0] live_out,
    output logic [NPIN-1:0] periph_in
);
    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        if (IMPL_MASK[i]) begin : g_impl
            logic       owns;
            spp_drive_t drv;
            assign owns         = periph_en[i] & periph_oe[i];
            assign drv          = pick_drive(owns, periph_out[i], dir_q[i], lat_q[i]);
            assign live_oe[i]   = drv.oe;
            assign live_out[i]  = drv.dat;
            assign periph_in[i] = feed_periph(pin_sync[i], owns, dir_q[i]);
        end else begin : g_absent
            assign live_oe[i]   = 1'b0;
            assign live_out[i]  = 1'b0;
            assign periph_in[i] = 1'b0;
        end
    end

endmodule

// File: rtl/spp_retain.sv
module spp_retain #(
    parameter int NPIN = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            retain,
    input  logic            release_clr,
    input  logic [NPIN-1:0] live_oe,
    input  logic [NPIN-1:0] live_out,
    output logic            release_flag,
    output logic            hold,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_out
);
    logic [NPIN-1:0] cap_oe;
    logic [NPIN-1:0] cap_out;

    always_ff @(posedge clk) begin
        if (rst)              release_flag <= 1'b0;
        else if (retain)      release_flag <= 1'b1;
        else if (release_clr) release_flag <= 1'b0;
    end

    assign hold = retain | release_flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_oe  <= '0;
            cap_out <= '0;
        end else if (!hold) begin
            cap_oe  <= live_oe;
            cap_out <= live_out;
        end
    end

    assign pad_oe  = hold ? cap_oe  : live_oe;
    assign pad_out = hold ? cap_out : live_out;

    // R9
    release_only_by_sw_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(release_flag) && !release_flag) |-> ($past(release_clr) && !$past(retain)));

endmodule

// File: rtl/shared_pin_port.sv
module shared_pin_port
    import spp_pkg::*;
#(
    parameter int              NPIN      = 8,
    parameter logic [NPIN-1:0] IMPL_MASK = 8'hBF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            bus_wr,
    input  logic            bus_rd,
    input  logic [1:0]      bus_addr,
    input  logic [NPIN-1:0] bus_wdata,
    output logic [NPIN-1:0] bus_rdata,
    input  logic [NPIN-1:0] periph_en,
    input  logic [NPIN-1:0] periph_oe,
    input  logic [NPIN-1:0] periph_out,
    output logic [NPIN-1:0] periph_in,
    input  logic [NPIN-1:0] pad_in,
    output logic [NPIN-1:0] pad_oe,
    output logic [NPIN-1:0] pad_out,
    input  logic            retain
);
    logic [NPIN-1:0] pin_sync;
    logic [NPIN-1:0] dir_q;
    logic [NPIN-1:0] lat_q;
    logic [NPIN-1:0] live_oe;
    logic [NPIN-1:0] live_out;
    logic            release_clr;
    logic            release_flag;
    logic            hold;
    logic [NPIN-1:0] owned;

    spp_sync #(.NPIN(NPIN)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .raw_in   (pad_in),
        .sync_out (pin_sync)
    );

    spp_regs #(.NPIN(NPIN), .IMPL_MASK(IMPL_MASK)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .bus_wr       (bus_wr),
        .bus_rd       (bus_rd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .pin_sync     (pin_sync),
        .release_flag (release_flag),
        .dir_q        (dir_q),
        .lat_q        (lat_q),
        .release_clr  (release_clr),
        .bus_rdata    (bus_rdata)
    );

    spp_pinmux #(.NPIN(NPIN), .IMPL_MASK(IMPL_MASK)) u_mux (
        .dir_q      (dir_q),
        .lat_q      (lat_q),
        .pin_sync   (pin_sync),
        .periph_en  (periph_en),
        .periph_oe  (periph_oe),
        .periph_out (periph_out),
        .live_oe    (live_oe),
        .live_out   (live_out),
        .periph_in  (periph_in)
    );

    spp_retain #(.NPIN(NPIN)) u_hold (
        .clk          (clk),
        .rst          (rst),
        .retain       (retain),
        .release_clr  (release_clr),
        .live_oe      (live_oe),
        .live_out     (live_out),
        .release_flag (release_flag),
        .hold         (hold),
        .pad_oe       (pad_oe),
        .pad_out      (pad_out)
    );

    assign owned = periph_en & periph_oe & IMPL_MASK;

    // R5
    periph_owns_chk: assert property (@(posedge clk) disable iff (rst)
        !hold |-> (((pad_oe & owned) == owned) && ((pad_out & owned) == (periph_out & owned))));

    // R7
    no_loop_through_chk: assert property (@(posedge clk) disable iff (rst)
        (periph_in & ~dir_q & ~owned) == '0);

    // R8
    unimpl_pins_chk: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe | pad_out | periph_in) & ~IMPL_MASK) == '0);

    // R9
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold) && !$past(rst)) |-> ($stable(pad_oe) && $stable(pad_out)));

endmodule

// File: tb/shared_pin_port_test.sv
`timescale 1ns/100ps
module shared_pin_port_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0, retain = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = '0, bus_rdata;
    logic [7:0] periph_en = '0, periph_oe = '0, periph_out = '0, periph_in;
    logic [7:0] pad_in = '0, pad_oe, pad_out;
    int checks = 0, failures = 0;
    bit done = 0;
    logic [7:0] rv;

    localparam logic [7:0] M = 8'hBF;  // bit 6 absent

    always #2.5 clk = ~clk;

    shared_pin_port uut (.*);

    // {dir, lat, pen, poe, pout, pad, exp_oe, exp_out, exp_pin}
    localparam logic [71:0] VEC [4] = '{
        {8'h00, 8'hA5, 8'h00, 8'h00, 8'h00, 8'hFF, 8'hBF, 8'hA5, 8'h00},
        {8'hFF, 8'h3C, 8'h0F, 8'h05, 8'hFF, 8'hAA, 8'h05, 8'h3D, 8'hAA},
        {8'hF0, 8'h0F, 8'hFF, 8'hC3, 8'h81, 8'h5A, 8'h8F, 8'h8D, 8'h12},
        {8'h55, 8'hFF, 8'hF0, 8'h0F, 8'h00, 8'hFF, 8'hAA, 8'hBF, 8'h15}
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R2 reset state
        chk("R2 pad_oe", pad_oe, 8'h00);
        rd(2'd0, rv); chk("R2 dir", rv, M);
        rd(2'd1, rv); chk("R2 lat", rv, 8'h00);
        rd(2'd3, rv); chk("R2 release", rv, 8'h00);

        // R8 absent bit ignored on write; R4 write via port address
        wr(2'd1, 8'hFF); rd(2'd1, rv); chk("R8 lat masked", rv, 8'hBF);
        wr(2'd2, 8'hC3); rd(2'd1, rv); chk("R4 port addr loads lat", rv, 8'h83);

        // table walk: R1 R5 R6 R7 R8
        foreach (VEC[k]) begin
            logic [7:0] vd, vl, ve, vo, vp, vpad, xoe, xout, xpin;
            {vd, vl, ve, vo, vp, vpad, xoe, xout, xpin} = VEC[k];
            wr(2'd0, vd);
            if (k == 1) wr(2'd2, vl); else wr(2'd1, vl);
            @(negedge clk);
            periph_en = ve; periph_oe = vo; periph_out = vp; pad_in = vpad;
            repeat (2) @(negedge clk);
            chk("R1/R5/R6 pad_oe", pad_oe, xoe);
            chk("R1/R5/R6 pad_out", pad_out, xout);
            chk("R7 periph_in", periph_in, xpin);
            rd(2'd0, rv); chk("R3 dir read", rv, vd & M);
            rd(2'd2, rv); chk("R5 pin view", rv, vpad & M);
        end
        periph_en = '0; periph_oe = '0;

        // R10 synchroniser depth
        wr(2'd0, 8'hFF);
        @(negedge clk); pad_in = 8'h00;
        repeat (3) @(negedge clk);
        pad_in = 8'h0F;
        @(negedge clk); chk("R10 after one edge", periph_in, 8'h00);
        @(negedge clk); chk("R10 after two edges", periph_in, 8'h0F);

        // R9 retention
        wr(2'd0, 8'h00); wr(2'd1, 8'h5A);
        repeat (2) @(negedge clk);
        chk("R9 pre pad_out", pad_out, 8'h1A);
        retain = 1'b1;
        wr(2'd1, 8'hFF); wr(2'd0, 8'hFF);
        chk("R9 held oe", pad_oe, 8'hBF);
        chk("R9 held out", pad_out, 8'h1A);
        wr(2'd3, 8'h00);
        rd(2'd3, rv); chk("R9 clear blocked under retain", rv, 8'h01);
        @(negedge clk); retain = 1'b0;
        repeat (2) @(negedge clk);
        chk("R9 held after wake", pad_out, 8'h1A);
        wr(2'd3, 8'h01);
        chk("R9 write 1 keeps hold", pad_oe, 8'hBF);
        rd(2'd3, rv); chk("R9 flag still set", rv, 8'h01);
        wr(2'd3, 8'h00);
        chk("R9 released oe", pad_oe, 8'h00);
        chk("R9 released out", pad_out, 8'hBF);
        rd(2'd3, rv); chk("R3 ctl read", rv, 8'h00);

        done = 1;
        finish_run();
    end
endmodule